// File: doc/BRIEF.md
# Flash Device ID Probe

This block runs once after every reset. It drives a byte-wide parallel NOR flash bus and asks the flash to identify itself. First it writes the read-identifier command. It then waits a settling interval and reads two identification bytes. Finally it writes the return-to-array command so that normal reads see stored data again.

The two bytes form a 16-bit identifier. The block compares this identifier with the two supported parts and reports one of two outcomes: a capacity code, or an unsupported-device flag. One detail is data dependent. The flash address of the second byte depends on the value of the first byte. A 0xB0 first byte moves the second byte from offset 1 to offset 2.

A system holds the flash bus for this block while `busy` is high. Once `done` rises, the system reads `id`, `size_sel`, `id_valid` and `id_error`. These results do not change until the next reset.

Top module: `flash_id_probe`

## Requirements
- R1: While `rst` is high, `busy` is 1, and `done`, `id_valid`, `id_error`, `id` and `size_sel` are all 0. Neither `fl_we` nor `fl_re` is asserted.
- R2: The first bus action after reset is a single-cycle write: `fl_we` is high, `fl_addr` is 0x8000 and `fl_wdata` is 0x90.
- R3: Between that command write and the first read strobe there are exactly `SETTLE_CYC` cycles with no strobe. The first read uses address 0.
- R4: A read presents `fl_re` for one cycle. The block samples `fl_rdata` in the following cycle.
- R5: The second read uses address 2 when the first byte is 0xB0. For any other first byte it uses address 1.
- R6: `id` equals the first byte in bits 15:8 and the second byte in bits 7:0.
- R7: After the second read, the block writes 0xFF to address 0x8000. Each probe makes exactly two writes and two reads, and `fl_we` and `fl_re` are never high together.
- R8: ID 0x89A6 gives `size_sel` = 2'b01 (1 MiB). ID 0xB0D4 gives `size_sel` = 2'b10 (4 MiB). Both set `id_valid` = 1 and `id_error` = 0.
- R9: Any other ID gives `id_error` = 1, `id_valid` = 0 and `size_sel` = 2'b00.
- R10: `busy` stays high from reset until `done` rises, and it falls in the same cycle. After that, all result outputs hold their values and the bus stays idle until the next reset.
- R11: A reset during a probe drops the partial result. The probe starts again from R2 after the reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fl_addr | output | ADDR_W | Flash byte address |
| fl_wdata | output | 8 | Flash write data |
| fl_we | output | 1 | Flash write strobe, one cycle per write |
| fl_re | output | 1 | Flash read strobe, data returned next cycle |
| fl_rdata | input | 8 | Flash read data |
| busy | output | 1 | Probe in progress |
| done | output | 1 | Probe finished, results valid |
| id | output | 16 | Combined identifier |
| size_sel | output | 2 | Capacity code: 00 none, 01 1 MiB, 10 4 MiB |
| id_valid | output | 1 | Identifier is a supported device |
| id_error | output | 1 | Identifier is not supported |

## Verification
Two situations can fall in the same cycle.

- **Address choice and data arrival.** The choice of the second-read address uses a byte that arrived only one cycle earlier. The bench sweeps all 256 first-byte values, with distinct contents at offsets 1 and 2. For each value it judges the address actually strobed against the expected 1-or-2 choice.
- **Reset and result capture.** A reset can land in the very cycle the return-to-array write is on the bus, one edge before the result is latched. The bench asserts reset on that cycle. It then checks two things:
  - `done` and the result flags stay clear;
  - after release, a complete fresh probe delivers the correct identifier.

// File: rtl/flash_probe_pkg.sv
package flash_probe_pkg;

  typedef enum logic [3:0] {
    ST_BOOT,
    ST_CMD,
    ST_WAIT,
    ST_RD_HI,
    ST_CAP_HI,
    ST_RD_LO,
    ST_CAP_LO,
    ST_EXIT,
    ST_FIN,
    ST_HOLD
  } probe_st_t;

  typedef enum logic [1:0] {
    CAP_NONE = 2'd0,
    CAP_1M   = 2'd1,
    CAP_4M   = 2'd2
  } cap_code_t;

  localparam logic [7:0] OP_READ_ID    = 8'h90;
  localparam logic [7:0] OP_READ_ARRAY = 8'hFF;

endpackage

// File: rtl/probe_delay.sv
module probe_delay #(
  parameter int CYC = 1500
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);
  localparam int CNT_W = (CYC < 2) ? 1 : $clog2(CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC - 1);

  logic [CNT_W-1:0] cnt;

  assign expire = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (!expire) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3: the wait counter never passes the settle length
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

endmodule

// File: rtl/probe_decode.sv
module probe_decode
  import flash_probe_pkg::*;
#(
  parameter logic [15:0] ID_SMALL = 16'h89A6,
  parameter logic [15:0] ID_LARGE = 16'hB0D4
) (
  input  logic [15:0] id_word,
  output cap_code_t   code,
  output logic        known
);
  always_comb begin
    code  = CAP_NONE;
    known = 1'b0;
    if (id_word == ID_SMALL) begin
      code  = CAP_1M;
      known = 1'b1;
    end else if (id_word == ID_LARGE) begin
      code  = CAP_4M;
      known = 1'b1;
    end
  end
endmodule

// File: rtl/probe_seq.sv
module probe_seq
  import flash_probe_pkg::*;
#(
  parameter int          ADDR_W     = 22,
  parameter int unsigned CMD_OFS    = 32'h8000,
  parameter logic [7:0]  ALT_HI     = 8'hB0,
  parameter int          SETTLE_CYC = 1500
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_wdata,
  output logic              fl_we,
  output logic              fl_re,
  input  logic [7:0]        fl_rdata,
  output logic [15:0]       id_word,
  output logic              fin,
  output logic              busy
);
  localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(CMD_OFS);
  localparam logic [ADDR_W-1:0] LO_NORM  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] LO_ALT   = ADDR_W'(2);

  probe_st_t  st;
  logic [7:0] hi_q;
  logic [7:0] lo_q;
  logic       wait_done;

  probe_delay #(.CYC(SETTLE_CYC)) u_delay (
    .clk    (clk),
    .rst    (rst),
    .run    (st == ST_WAIT),
    .expire (wait_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_BOOT;
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      unique case (st)
        ST_BOOT:   st <= ST_CMD;
        ST_CMD:    st <= ST_WAIT;
        ST_WAIT:   if (wait_done) st <= ST_RD_HI;
        ST_RD_HI:  st <= ST_CAP_HI;
        ST_CAP_HI: begin
          hi_q <= fl_rdata;
          st   <= ST_RD_LO;
        end
        ST_RD_LO:  st <= ST_CAP_LO;
        ST_CAP_LO: begin
          lo_q <= fl_rdata;
          st   <= ST_EXIT;
        end
        ST_EXIT:   st <= ST_FIN;
        ST_FIN:    st <= ST_HOLD;
        ST_HOLD:   st <= ST_HOLD;
        default:   st <= ST_BOOT;
      endcase
    end
  end

  always_comb begin
    fl_addr  = '0;
    fl_wdata = '0;
    fl_we    = 1'b0;
    fl_re    = 1'b0;
    case (st)
      ST_CMD: begin
        fl_we    = 1'b1;
        fl_addr  = CMD_ADDR;
        fl_wdata = OP_READ_ID;
      end
      ST_RD_HI: fl_re = 1'b1;
      ST_RD_LO: begin
        fl_re   = 1'b1;
        fl_addr = (hi_q == ALT_HI) ? LO_ALT : LO_NORM;
      end
      ST_EXIT: begin
        fl_we    = 1'b1;
        fl_addr  = CMD_ADDR;
        fl_wdata = OP_READ_ARRAY;
      end
      default: ;
    endcase
  end

  assign id_word = {hi_q, lo_q};
  assign fin     = (st == ST_FIN);
  assign busy    = (st != ST_HOLD);

  // R7: the two strobes never overlap
  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(fl_we && fl_re));

  // R5: the second read always follows capture of the first byte
  p_lo_after_hi_r5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RD_LO) |-> ($past(st) == ST_CAP_HI));

endmodule

// File: rtl/flash_id_probe.sv
module flash_id_probe
  import flash_probe_pkg::*;
#(
  parameter int          ADDR_W     = 22,
  parameter int          SETTLE_CYC = 1500,
  parameter int unsigned CMD_OFS    = 32'h8000,
  parameter logic [7:0]  ALT_HI     = 8'hB0,
  parameter logic [15:0] ID_SMALL   = 16'h89A6,
  parameter logic [15:0] ID_LARGE   = 16'hB0D4
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_wdata,
  output logic              fl_we,
  output logic              fl_re,
  input  logic [7:0]        fl_rdata,
  output logic              busy,
  output logic              done,
  output logic [15:0]       id,
  output logic [1:0]        size_sel,
  output logic              id_valid,
  output logic              id_error
);
  logic [15:0] id_word;
  logic        fin;
  cap_code_t   code;
  logic        known;

  probe_seq #(
    .ADDR_W     (ADDR_W),
    .CMD_OFS    (CMD_OFS),
    .ALT_HI     (ALT_HI),
    .SETTLE_CYC (SETTLE_CYC)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .fl_addr  (fl_addr),
    .fl_wdata (fl_wdata),
    .fl_we    (fl_we),
    .fl_re    (fl_re),
    .fl_rdata (fl_rdata),
    .id_word  (id_word),
    .fin      (fin),
    .busy     (busy)
  );

  probe_decode #(
    .ID_SMALL (ID_SMALL),
    .ID_LARGE (ID_LARGE)
  ) u_dec (
    .id_word (id_word),
    .code    (code),
    .known   (known)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      id       <= '0;
      size_sel <= '0;
      id_valid <= 1'b0;
      id_error <= 1'b0;
    end else if (fin) begin
      done     <= 1'b1;
      id       <= id_word;
      size_sel <= code;
      id_valid <= known;
      id_error <= !known;
    end
  end

  // R10: busy and done are complementary
  p_busy_done_r10: assert property (@(posedge clk) disable iff (rst)
    busy != done);

  // R10: results hold once done
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    $past(done) |-> (done && $stable(id) && $stable(size_sel)
                     && $stable(id_valid) && $stable(id_error)));

  // R10: the bus is idle after completion
  p_idle_bus_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> (!fl_we && !fl_re));

  // R9: exactly one outcome flag once finished
  p_outcome_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (id_valid != id_error));

  // R8: a supported device always carries a capacity code
  p_size_r8: assert property (@(posedge clk) disable iff (rst)
    id_valid |-> (size_sel != 2'b00));

endmodule

// File: tb/sim_flash_id_probe.sv
module sim_flash_id_probe;
  localparam int AW     = 22;
  localparam int SETTLE = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_wdata;
  logic          fl_we, fl_re;
  logic [7:0]    fl_rdata = 8'h00;
  logic          busy, done, id_valid, id_error;
  logic [15:0]   id;
  logic [1:0]    size_sel;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  flash_id_probe #(.ADDR_W(AW), .SETTLE_CYC(SETTLE)) u0 (
    .clk(clk), .rst(rst), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_we(fl_we), .fl_re(fl_re), .fl_rdata(fl_rdata), .busy(busy),
    .done(done), .id(id), .size_sel(size_sel), .id_valid(id_valid),
    .id_error(id_error)
  );

  // flash model: identifier mode after 0x90, array mode after 0xFF
  logic [7:0] idmem [0:3];
  logic       idmode = 1'b0;
  always @(posedge clk) begin
    if (fl_re) fl_rdata <= (idmode && fl_addr < 4) ? idmem[fl_addr[1:0]] : 8'h5A;
    if (fl_we && fl_addr == 22'h8000) begin
      if (fl_wdata == 8'h90) idmode <= 1'b1;
      else if (fl_wdata == 8'hFF) idmode <= 1'b0;
    end
  end

  // bus monitor
  int            n_wr, n_rd, n_both, gap;
  bit            gap_on;
  logic [AW-1:0] wr_a [0:3];
  logic [7:0]    wr_d [0:3];
  logic [AW-1:0] rd_a [0:3];
  always @(negedge clk) begin
    if (!rst) begin
      if (fl_we && fl_re) n_both++;
      if (fl_we) begin
        if (n_wr < 4) begin wr_a[n_wr] = fl_addr; wr_d[n_wr] = fl_wdata; end
        if (n_wr == 0) gap_on = 1'b1;
        n_wr++;
      end else if (fl_re) begin
        if (n_rd < 4) rd_a[n_rd] = fl_addr;
        if (n_rd == 0) gap_on = 1'b0;
        n_rd++;
      end else if (gap_on) begin
        gap++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    n_wr = 0; n_rd = 0; n_both = 0; gap = 0; gap_on = 1'b0;
  endtask

  task automatic wait_done();
    int k = 0;
    while (!done && k < 300) begin @(negedge clk); k++; end
    chk(done, "R10 watchdog", int'(done), 1);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 1'b1 && done == 1'b0, "R1 busy/done", {busy, done}, 2'b10);
    chk(id == 16'h0 && size_sel == 2'b00 && !id_valid && !id_error,
        "R1 results", {id, size_sel, id_valid, id_error}, 0);
    chk(!fl_we && !fl_re, "R1 strobes", {fl_we, fl_re}, 0);
    clear_log();
    rst = 1'b0;
  endtask

  task automatic probe(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    logic [15:0] exp_id;
    logic [1:0]  exp_sz;
    logic [AW-1:0] exp_a2;
    logic [15:0] id_s;
    idmem[0] = b0; idmem[1] = b1; idmem[2] = b2; idmem[3] = 8'h00;
    exp_a2 = (b0 == 8'hB0) ? 22'd2 : 22'd1;
    exp_id = {b0, (b0 == 8'hB0) ? b2 : b1};
    exp_sz = (exp_id == 16'h89A6) ? 2'b01 : (exp_id == 16'hB0D4) ? 2'b10 : 2'b00;
    do_reset();
    wait_done();
    chk(!busy, "R10 busy low at done", int'(busy), 0);
    chk(n_wr == 2 && n_rd == 2 && n_both == 0, "R7 transaction count",
        n_wr * 16 + n_rd, 8'h22);
    chk(wr_a[0] == 22'h8000 && wr_d[0] == 8'h90, "R2 id command",
        int'(wr_a[0]) * 256 + wr_d[0], 32'h800090);
    chk(gap == SETTLE, "R3 settle gap", gap, SETTLE);
    chk(rd_a[0] == 22'd0, "R3 first read addr", int'(rd_a[0]), 0);
    chk(rd_a[1] == exp_a2, "R5 second read addr", int'(rd_a[1]), int'(exp_a2));
    chk(wr_a[1] == 22'h8000 && wr_d[1] == 8'hFF && !idmode, "R7 exit command",
        int'(wr_a[1]) * 256 + wr_d[1], 32'h8000FF);
    chk(id == exp_id, "R6/R4 id value", int'(id), int'(exp_id));
    chk(size_sel == exp_sz, "R8 size code", int'(size_sel), int'(exp_sz));
    chk(id_valid == (exp_sz != 0) && id_error == (exp_sz == 0), "R9 outcome flags",
        {id_valid, id_error}, {exp_sz != 0, exp_sz == 0});
    id_s = id;
    repeat (5) @(negedge clk);
    chk(done && id == id_s && n_wr == 2 && n_rd == 2, "R10 hold and idle bus",
        int'(id), int'(id_s));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 global watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idmem[0] = 0; idmem[1] = 0; idmem[2] = 0; idmem[3] = 0;
    clear_log();
    @(negedge clk);
    // supported parts and near misses
    probe(8'h89, 8'hA6, 8'h00);  // R8 1 MiB
    probe(8'hB0, 8'h00, 8'hD4);  // R8 4 MiB, R5 alternate offset
    probe(8'hB0, 8'hD4, 8'h00);  // R9 offset 1 must be ignored
    probe(8'h89, 8'h00, 8'hA6);  // R9 offset 2 must be ignored
    probe(8'hFF, 8'hFF, 8'hFF);  // R9
    // sweep of every first byte
    for (int h = 0; h < 256; h++) probe(8'(h), 8'(h) ^ 8'h3C, ~8'(h));

    // R11: reset during the settle wait
    idmem[0] = 8'hB0; idmem[1] = 8'h11; idmem[2] = 8'hD4;
    do_reset();
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!done && busy && !id_valid, "R11 abort in wait", {done, busy}, 2'b01);
    clear_log();
    rst = 1'b0;
    wait_done();
    chk(id == 16'hB0D4 && size_sel == 2'b10 && n_wr == 2, "R11 rerun after wait abort",
        int'(id), 16'hB0D4);

    // R11: reset on the exit-command cycle, one edge before capture
    do_reset();
    begin
      int k = 0;
      while (!(fl_we && fl_wdata == 8'hFF) && k < 100) begin @(negedge clk); k++; end
    end
    rst = 1'b1;
    @(negedge clk);
    chk(!done && !id_valid && !id_error && id == 16'h0, "R11 abort at exit write",
        int'(id), 0);
    @(negedge clk);
    chk(!done && busy, "R11 no late capture", {done, busy}, 2'b01);
    clear_log();
    rst = 1'b0;
    wait_done();
    chk(id == 16'hB0D4 && id_valid && n_wr == 2 && n_rd == 2,
        "R11 rerun after exit abort", int'(id), 16'hB0D4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule